// File: doc/BRIEF.md
# Auto-Reload Event Timer

This block is a small timer for event generation, such as an operating-system tick. It is reached through a simple synchronous register bus. A 16-bit up-counter advances on ticks from a power-of-two clock divider. When the counter has reached a programmable reload value, it returns to zero on its next tick and sets a match flag. The interrupt line is the match flag gated by an enable bit. The timer can run one period and then stop, or it can repeat without end.

Software programs the timer while it is switched off: interrupt enable and divider code. It then switches the timer on and writes the reload value, which is accepted only while the timer is on. Last, it issues a single or continuous start. A control state machine has four states:

- `ST_OFF`: disabled; counter and divider held at zero.
- `ST_IDLE`: enabled but not counting.
- `ST_ONCE`: a single run.
- `ST_LOOP`: continuous running.

The transitions are:

- `go_off`: any state moves to `ST_OFF` on a control write with enable clear.
- `arm`: `ST_OFF` moves to `ST_IDLE` on a control write with enable set and no start bit.
- `go_once`: `ST_OFF` or `ST_IDLE` moves to `ST_ONCE`. It also moves `ST_LOOP` to `ST_ONCE`, keeping the counter.
- `go_loop`: `ST_OFF`, `ST_IDLE` or `ST_ONCE` moves to `ST_LOOP`.
- `done`: `ST_ONCE` returns to `ST_IDLE` on the tick where the counter matches the reload value.

Top module: `lpt_event_timer`

## Requirements
- R1: After reset, status, interrupt enable, divider code, control and counter all read 0, the reload register reads 1, and `irq` is low.
- R2: A read returns data on `bus_rdata` after the clock edge that samples `bus_rd` high, and `bus_rdata` holds its value while `bus_rd` is low. The byte offsets are:
  - 0x00: status, match flag in bit 0.
  - 0x04: flag clear.
  - 0x08: interrupt enable, bit 0.
  - 0x0C: configuration, divider code in bits 11:9.
  - 0x10: control. Bit 0 is enable, bit 1 is single start, bit 2 is continuous start.
  - 0x1C: reload value, bits 15:0.
  - 0x20: counter, bits 15:0.

  The clear register, unmapped offsets and the control start bits read 0.
- R3: A write to interrupt enable is ignored while the enable bit in control is 1.
- R4: A write to the reload register is ignored while the enable bit is 0, and a write of 0 is always ignored.
- R5: With divider code n, a running counter advances once every 2^n clock cycles, for n from 0 to 7.
- R6: In continuous mode, t cycles after the start edge the counter equals floor(t/2^n) mod (A+1), where A is the reload value. The match flag is set at the edge where the counter leaves A for 0.
- R7: In single mode the counter follows the same sequence for one period. It then stays at 0 with the state in `ST_IDLE` until a new start, and the flag is set at the period's end.
- R8: Writing 1 to bit 0 of the clear register clears the flag, and writing 0 has no effect. A match at the same edge as a clear leaves the flag set.
- R9: `irq` is high exactly while both the flag and the interrupt enable are 1. It stays high until the flag is cleared.
- R10: A control write with enable 0 stops the timer and forces the counter and divider to 0. A retained flag is left untouched. A later start counts again from 0.
- R11: A control write with both start bits set selects continuous mode. A control write with start bits but enable 0 only stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus, divider and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq | output | 1 | Match interrupt, level |

## Verification
The assertions watch the register lock rules on every cycle:
- interrupt enable is frozen while the timer is on, and reload is frozen while it is off;
- the reload value is never zero;
- the counter is at zero while disabled;
- every rise of the flag follows a counter-equals-reload cycle;
- a clear without a simultaneous match empties the flag;
- the interrupt holds between clears.

Only the bench's scenarios can show the actual counter sequence and period for each divider code. The same goes for the point where a single run stops and the decoding of combined start bits. It also covers the edge-exact race between a match and a clear, and the restart from zero after a stop.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_STAT = 8'h00;
    localparam logic [7:0] OFS_CLR  = 8'h04;
    localparam logic [7:0] OFS_IE   = 8'h08;
    localparam logic [7:0] OFS_CFG  = 8'h0C;
    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_ARR  = 8'h1C;
    localparam logic [7:0] OFS_CNT  = 8'h20;

    // Bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_ONCE = 1;
    localparam int BIT_LOOP = 2;
    localparam int BIT_FLAG = 0;
    localparam int PSC_LSB  = 9;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_ONCE = 2'd2,
        ST_LOOP = 2'd3
    } lpt_state_e;

    // Control strobes decoded from one control write
    typedef struct packed {
        logic go_off;
        logic arm;
        logic go_once;
        logic go_loop;
    } lpt_cmd_t;

endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              match,
    input  logic [CNT_W-1:0]  cnt,
    output logic              en_q,
    output logic              ie_q,
    output logic              flag_q,
    output logic [PSC_W-1:0]  psc_q,
    output logic [CNT_W-1:0]  arr_q,
    output lpt_cmd_t          cmd,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_clr, wr_ie, wr_cfg, wr_ctrl, wr_arr;
    logic [CNT_W-1:0] arr_wval;
    logic [DATA_W-1:0] rd_mux;

    assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
    assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(OFS_IE));
    assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_arr  = bus_wr && (bus_addr == ADDR_W'(OFS_ARR));
    assign arr_wval = bus_wdata[CNT_W-1:0];

    // Control decode: continuous start outranks single start
    always_comb begin
        cmd.go_off  = wr_ctrl && !bus_wdata[BIT_EN];
        cmd.arm     = wr_ctrl &&  bus_wdata[BIT_EN];
        cmd.go_loop = wr_ctrl &&  bus_wdata[BIT_EN] && bus_wdata[BIT_LOOP];
        cmd.go_once = wr_ctrl &&  bus_wdata[BIT_EN] && bus_wdata[BIT_ONCE]
                      && !bus_wdata[BIT_LOOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            psc_q <= '0;
            arr_q <= CNT_W'(1);
        end else begin
            if (wr_ctrl) begin
                en_q <= bus_wdata[BIT_EN];
            end
            if (wr_ie && !en_q) begin
                ie_q <= bus_wdata[BIT_FLAG];
            end
            if (wr_cfg) begin
                psc_q <= bus_wdata[PSC_LSB +: PSC_W];
            end
            if (wr_arr && en_q && (arr_wval != '0)) begin
                arr_q <= arr_wval;
            end
        end
    end

    // Match flag: a set outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (wr_clr && bus_wdata[BIT_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_STAT): rd_mux = DATA_W'(flag_q);
            ADDR_W'(OFS_IE):   rd_mux = DATA_W'(ie_q);
            ADDR_W'(OFS_CFG):  rd_mux = DATA_W'(psc_q) << PSC_LSB;
            ADDR_W'(OFS_CTRL): rd_mux = DATA_W'(en_q);
            ADDR_W'(OFS_ARR):  rd_mux = DATA_W'(arr_q);
            ADDR_W'(OFS_CNT):  rd_mux = DATA_W'(cnt);
            default:           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);

    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    // limit = 2^code - 1 as a thermometer mask
    for (genvar i = 0; i < DIV_W; i++) begin : g_limit
        assign limit[i] = (int'(code) > i);
    end

    assign tick = run && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/lpt_fsm.sv
module lpt_fsm
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lpt_cmd_t         cmd,
    input  logic             tick,
    input  logic [CNT_W-1:0] arr,
    output lpt_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             match
);

    lpt_state_e state_nxt;
    logic       run_nxt;

    assign run   = (state == ST_ONCE) || (state == ST_LOOP);
    assign match = run && tick && (cnt == arr) && !cmd.go_off;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (cmd.go_loop)      state_nxt = ST_LOOP;
                else if (cmd.go_once) state_nxt = ST_ONCE;
                else if (cmd.arm)     state_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd.go_off)       state_nxt = ST_OFF;
                else if (cmd.go_loop) state_nxt = ST_LOOP;
                else if (cmd.go_once) state_nxt = ST_ONCE;
            end
            ST_ONCE: begin
                if (cmd.go_off)       state_nxt = ST_OFF;
                else if (cmd.go_loop) state_nxt = ST_LOOP;
                else if (match)       state_nxt = ST_IDLE;
            end
            ST_LOOP: begin
                if (cmd.go_off)       state_nxt = ST_OFF;
                else if (cmd.go_once) state_nxt = ST_ONCE;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    assign run_nxt = (state_nxt == ST_ONCE) || (state_nxt == ST_LOOP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Counter output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_nxt) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == arr) ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lpt_event_timer.sv
module lpt_event_timer
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             en_q, ie_q, flag_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] arr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run, tick, match;
    lpt_cmd_t         cmd;
    lpt_state_e       state;

    lpt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .match(match), .cnt(cnt_q),
        .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
        .psc_q(psc_q), .arr_q(arr_q), .cmd(cmd),
        .bus_rdata(bus_rdata)
    );

    lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .code(psc_q), .tick(tick)
    );

    lpt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(tick), .arr(arr_q),
        .state(state), .cnt(cnt_q), .run(run), .match(match)
    );

    assign irq = flag_q && ie_q;

endmodule

// File: rtl/lpt_event_timer_chk.sv
module lpt_event_timer_chk
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              en_q,
    input logic              ie_q,
    input logic              flag_q,
    input logic              match,
    input logic [CNT_W-1:0]  arr_q,
    input logic [CNT_W-1:0]  cnt_q
);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2

    AST_IE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_IE) && en_q) |=> $stable(ie_q)); // R3

    AST_ARR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ARR) && !en_q) |=> $stable(arr_q)); // R4

    AST_ARR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        arr_q != '0); // R4

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cnt_q == arr_q)); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata[BIT_FLAG] && !match)
        |=> !flag_q); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && (bus_addr == ADDR_W'(OFS_CLR) ||
                             bus_addr == ADDR_W'(OFS_IE)))) |=> irq); // R9

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (cnt_q == '0)); // R10

endmodule

bind lpt_event_timer lpt_event_timer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q), .match(match),
    .arr_q(arr_q), .cnt_q(cnt_q)
);

// File: tb/lpt_event_timer_tb.sv
`timescale 1ns/1ps
module lpt_event_timer_tb;

    localparam logic [7:0] A_STAT = 8'h00, A_CLR = 8'h04, A_IE = 8'h08,
                           A_CFG = 8'h0C, A_CTRL = 8'h10, A_ARR = 8'h1C,
                           A_CNT = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errs = 0, checks = 0, now = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lpt_event_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic int exp_cnt(int t, int a, int n, bit single);
        int p = (a + 1) << n;
        if (t < 0) return 0;
        if (single && t >= p) return 0;
        return (t >> n) % (a + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, now);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        now++;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        cyc();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setup(int a, int n, bit ie);
        wr(A_CTRL, 0);
        wr(A_CLR, 1);
        wr(A_IE, 32'(ie));
        wr(A_CFG, 32'(n) << 9);
        wr(A_CTRL, 1);
        wr(A_ARR, 32'(a));
    endtask

    // Poll counter each cycle, checking counter, irq and final flag
    task automatic poll(string req, int w, int a, int n, bit single, bit ie,
                        bit pre, int len);
        logic [31:0] d;
        int p = (a + 1) << n;
        for (int k = 0; k < len; k++) begin
            rd(A_CNT, d);
            check(req, int'(d), exp_cnt(now - 1 - w, a, n, single));
            check({req, " R9 irq"}, int'(irq),
                  int'(ie && (pre || (now - w) >= p)));
        end
        rd(A_STAT, d);
        check({req, " flag"}, int'(d), int'(pre || (now - 1 - w) >= p));
    endtask

    initial begin
        logic [31:0] d;
        int w;
        void'($urandom(32'h5EED_0042));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset values
        check("R1 irq", int'(irq), 0);
        rd(A_STAT, d); check("R1 status", int'(d), 0);
        rd(A_IE, d);   check("R1 ie", int'(d), 0);
        rd(A_CFG, d);  check("R1 cfg", int'(d), 0);
        rd(A_CTRL, d); check("R1 ctrl", int'(d), 0);
        rd(A_ARR, d);  check("R1 reload", int'(d), 1);
        rd(A_CNT, d);  check("R1 counter", int'(d), 0);

        // R2 unmapped and clear register read 0; cfg field position
        rd(8'h14, d); check("R2 unmapped", int'(d), 0);
        rd(A_CLR, d); check("R2 clear reads 0", int'(d), 0);
        wr(A_CFG, 32'h5 << 9);
        rd(A_CFG, d); check("R2 cfg bits 11:9", int'(d), 32'h5 << 9);

        // R4 reload locked while disabled, zero ignored
        wr(A_ARR, 5);
        rd(A_ARR, d); check("R4 reload while off", int'(d), 1);
        wr(A_CTRL, 1);
        wr(A_ARR, 0);
        rd(A_ARR, d); check("R4 reload zero", int'(d), 1);
        wr(A_ARR, 9);
        rd(A_ARR, d); check("R4 reload while on", int'(d), 9);

        // R3 interrupt enable locked while enabled
        wr(A_IE, 1);
        rd(A_IE, d); check("R3 ie while on", int'(d), 0);
        wr(A_CTRL, 0);
        wr(A_IE, 1);
        rd(A_IE, d); check("R3 ie while off", int'(d), 1);

        // R5 largest divider code
        setup(1, 7, 0);
        wr(A_CTRL, 5); w = now;
        poll("R5 code7", w, 1, 7, 0, 0, 0, 300);

        // R6 / R7 / R5 random configurations
        for (int it = 0; it < 10; it++) begin
            int a = int'($urandom_range(1, 6));
            int n = int'($urandom_range(0, 2));
            bit s = 1'($urandom_range(0, 1));
            bit ie = 1'($urandom_range(0, 1));
            setup(a, n, ie);
            wr(A_CTRL, s ? 32'h3 : 32'h5); w = now;
            poll(s ? "R7 single" : "R6 loop", w, a, n, s, ie, 0,
                 (((a + 1) << n) * 2) + 5);
        end

        // R7 start bits self-clear, restart of a single run
        setup(4, 1, 1);
        wr(A_CTRL, 3); w = now;
        poll("R7 single", w, 4, 1, 1, 1, 0, 30);
        rd(A_CTRL, d); check("R7 ctrl start bits", int'(d), 1);
        wr(A_CLR, 1);
        wr(A_CTRL, 3); w = now;
        poll("R7 restart", w, 4, 1, 1, 1, 0, 25);

        // R8 match beats a clear at the same edge; R9 irq drop
        setup(1, 0, 1);
        wr(A_CTRL, 5); w = now;       // matches at edges w+2k
        cyc();                         // edge w+1
        wr(A_CLR, 1);                  // edge w+2, a match edge
        rd(A_STAT, d); check("R8 set wins", int'(d), 1);  // edge w+3
        wr(A_CLR, 0);                  // edge w+4
        check("R9 irq held", int'(irq), 1);
        wr(A_CLR, 1);                  // edge w+5, no match
        check("R9 irq cleared", int'(irq), 0);
        rd(A_STAT, d); check("R8 clear", int'(d), 0);

        // R10 stop keeps flag, clears counter, restart from zero
        setup(3, 1, 1);
        wr(A_CTRL, 5); w = now;
        poll("R10 pre", w, 3, 1, 0, 1, 0, 20);
        wr(A_CTRL, 0);
        rd(A_CNT, d);  check("R10 counter zero", int'(d), 0);
        rd(A_STAT, d); check("R10 flag kept", int'(d), 1);
        wr(A_CLR, 0);
        rd(A_STAT, d); check("R8 write 0 no effect", int'(d), 1);
        check("R9 irq while off", int'(irq), 1);
        wr(A_CTRL, 5); w = now;
        poll("R10 restart", w, 3, 1, 0, 1, 1, 12);

        // R11 both start bits select continuous; start with enable 0 stops
        setup(2, 0, 0);
        wr(A_CTRL, 7); w = now;
        poll("R11 both bits", w, 2, 0, 0, 0, 0, 12);
        wr(A_CTRL, 6);
        rd(A_CTRL, d); check("R11 ctrl off", int'(d), 0);
        repeat (5) cyc();
        rd(A_CNT, d);  check("R11 stopped", int'(d), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule